// File: doc/BRIEF.md
# Stallable Two-Stage Smoothing and Patch Window Pipeline

This block takes a raster stream of 8-bit pixels and builds two windows over it, one after the other. The first stage keeps seven image rows in a shift chain. Its 7x7 tap window feeds a separable binomial smoothing kernel. Each smoothed pixel is pushed into a second shift chain. That chain holds 31 rows and exposes a 31x31 patch window to a downstream descriptor engine. Both chains advance together, one step for each accepted input pixel. Because descriptors are computed while the stream is still flowing, no whole smoothed frame has to be stored.

An upstream detector raises a hit flag together with an input pixel. When that pixel has been shifted in and the resulting patch is a valid interior patch, the controller freezes both chains. It then asserts a busy strobe toward the descriptor engine and drops input ready until the engine returns a one-cycle done pulse. Accepting resumes in the cycle after done. The image width is a parameter. Full-size rows of 640 pixels and reduced rows of 533 pixels are set through it, and the default is a small width for compact builds.

Top module: `lbp_top`

## Requirements
- R1: After reset, pixReady is 1, winBusy is 0 and winValid is 0, and every stored pixel in both chains is 0.
- R2: A smoothed pixel is round(S/4096), where S is the sum of w[i]*w[j]*p over the 7x7 first-stage window with w = 1,6,15,20,15,6,1. Rounding is done by adding 2048 and shifting right by 12.
- R3: After k accepted pixels p[0..k-1], the smoothed value pushed on the accept of pixel m is the one centred on raw pixel m-1-(3W+3). Patch element (row r, column c), with r=0 the oldest row and c=0 the leftmost column, sits in winOut bits [(r*31+c)*8 +: 8] and holds the smoothed value pushed on the accept of pixel k-1-((30-r)*W+(30-c)). Values not yet pushed read as 0.
- R4: winValid is 1 exactly when k >= 36W+38 and the centre column (k-1-(18W+19)) mod W lies in [18, W-19].
- R5: An accepted pixel with featHit=1 whose resulting patch is valid sets winBusy in the next cycle. The patch then presented is centred on raw pixel k-1-(18W+19).
- R6: An accepted pixel with featHit=1 whose resulting patch is not valid causes no freeze: winBusy stays 0 and pixReady stays 1.
- R7: While winBusy is 1, pixReady is 0, offered pixels are not taken, and winOut does not change.
- R8: A descDone pulse while busy clears winBusy and raises pixReady in the next cycle, and no pixel is lost across the freeze.
- R9: Both chains shift once for each accepted pixel and never in a cycle with pixValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 8 | Input pixel |
| pixValid | input | 1 | Input pixel valid |
| pixReady | output | 1 | Block can accept a pixel |
| featHit | input | 1 | Feature flag qualifying the offered pixel |
| winOut | output | WIN2*WIN2*8 | Flattened smoothed patch window |
| winValid | output | 1 | Patch is a fully populated interior patch |
| winBusy | output | 1 | Patch is frozen for the descriptor engine |
| descDone | input | 1 | One-cycle pulse ending the freeze |

## Verification
winValid and winBusy are registered one clock edge after the edge that accepts a pixel. The bench therefore drives on the falling edge, lets one rising edge pass, and compares both at the next falling edge against a model of the accepted count. The patch is due in the first busy cycle. It is compared in full against smoothed values computed from the raw stream, and compared again after several held cycles in which a stray pixel is offered. The release is checked at the falling edge after the rising edge that samples descDone.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  typedef struct packed {
    logic shiftEn;
  } lbp_strobe_t;

  function automatic int binomTap(input int i);
    case (i)
      0, 6: binomTap = 1;
      1, 5: binomTap = 6;
      2, 4: binomTap = 15;
      default: binomTap = 20;
    endcase
  endfunction

endpackage

// File: rtl/lbp_ctrl.sv
module lbp_ctrl
  import lbp_pkg::*;
#(
  parameter int W = 64,
  parameter int WIN2 = 31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  input  logic        featHit,
  input  logic        descDone,
  output logic        pixReady,
  output logic        winValid,
  output logic        winBusy,
  output lbp_strobe_t strobe
);
  localparam int H      = 3 + (WIN2 - 1) / 2;
  localparam int FILL   = 2 * H * W + 2 * H + 2;
  localparam int CW     = $clog2(FILL + 1);
  localparam int COLW   = $clog2(W);
  localparam int CSTART = W - H - 2;
  localparam int LO     = H;
  localparam int HI     = W - 1 - H;

  logic            busy;
  logic [CW-1:0]   fillCnt;
  logic [COLW-1:0] ctrCol;
  logic [COLW-1:0] nextCol;
  logic            accept;
  logic            nextFull;
  logic            validNext;

  function automatic logic colOk(input logic [COLW-1:0] col);
    colOk = (col >= COLW'(LO)) && (col <= COLW'(HI));
  endfunction

  always_comb begin
    accept    = pixValid && !busy;
    nextCol   = (ctrCol == COLW'(W - 1)) ? '0 : ctrCol + 1'b1;
    nextFull  = (fillCnt >= CW'(FILL - 1));
    validNext = nextFull && colOk(nextCol);
    strobe.shiftEn = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      fillCnt <= '0;
      ctrCol  <= COLW'(CSTART);
    end else begin
      if (accept) begin
        ctrCol <= nextCol;
        if (fillCnt != CW'(FILL)) fillCnt <= fillCnt + 1'b1;
      end
      if (!busy && accept && featHit && validNext) busy <= 1'b1;
      else if (busy && descDone) busy <= 1'b0;
    end
  end

  assign pixReady = !busy;
  assign winBusy  = busy;
  assign winValid = (fillCnt == CW'(FILL)) && colOk(ctrCol);

endmodule

// File: rtl/lbp_datapath.sv
module lbp_datapath
  import lbp_pkg::*;
#(
  parameter int W = 64,
  parameter int WIN2 = 31
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lbp_strobe_t            strobe,
  input  logic [7:0]             pixIn,
  output logic [WIN2*WIN2*8-1:0] winOut
);
  localparam int K1 = 7;
  localparam int L1 = (K1 - 1) * W + K1;
  localparam int L2 = (WIN2 - 1) * W + WIN2;

  logic [7:0]  s1 [L1];
  logic [7:0]  s2 [L2];
  logic [21:0] acc;
  logic [7:0]  smooth;

  always_comb begin
    acc = '0;
    for (int r = 0; r < K1; r++)
      for (int c = 0; c < K1; c++)
        acc = acc + 22'(binomTap(r) * binomTap(c)) * 22'(s1[r*W+c]);
    smooth = 8'((acc + 22'd2048) >> 12);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < L1; j++) s1[j] <= '0;
      for (int j = 0; j < L2; j++) s2[j] <= '0;
    end else if (strobe.shiftEn) begin
      s1[0] <= pixIn;
      for (int j = 1; j < L1; j++) s1[j] <= s1[j-1];
      s2[0] <= smooth;
      for (int j = 1; j < L2; j++) s2[j] <= s2[j-1];
    end
  end

  for (genvar r = 0; r < WIN2; r++) begin : g_row
    for (genvar c = 0; c < WIN2; c++) begin : g_col
      assign winOut[(r*WIN2+c)*8 +: 8] = s2[(WIN2-1-r)*W + (WIN2-1-c)];
    end
  end

endmodule

// File: rtl/lbp_top.sv
module lbp_top
  import lbp_pkg::*;
#(
  parameter int W = 64,
  parameter int WIN2 = 31
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             pixIn,
  input  logic                   pixValid,
  output logic                   pixReady,
  input  logic                   featHit,
  output logic [WIN2*WIN2*8-1:0] winOut,
  output logic                   winValid,
  output logic                   winBusy,
  input  logic                   descDone
);
  lbp_strobe_t strobe;

  lbp_ctrl #(.W(W), .WIN2(WIN2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .featHit(featHit),
    .descDone(descDone), .pixReady(pixReady), .winValid(winValid),
    .winBusy(winBusy), .strobe(strobe)
  );

  lbp_datapath #(.W(W), .WIN2(WIN2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIn(pixIn), .winOut(winOut)
  );

endmodule

// File: rtl/lbp_checker.sv
module lbp_checker #(
  parameter int W = 64,
  parameter int WIN2 = 31
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pixValid,
  input logic                   pixReady,
  input logic                   featHit,
  input logic [WIN2*WIN2*8-1:0] winOut,
  input logic                   winValid,
  input logic                   winBusy,
  input logic                   descDone
);
  assert_ready_low_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    winBusy |-> !pixReady);

  assert_window_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (winBusy && $past(winBusy)) |-> $stable(winOut));

  assert_busy_needs_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    winBusy |-> winValid);

  assert_freeze_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(winBusy) |-> $past(pixValid && pixReady && featHit));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (winBusy && descDone) |=> (!winBusy && pixReady));
endmodule

bind lbp_top lbp_checker #(.W(W), .WIN2(WIN2)) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixReady(pixReady),
  .featHit(featHit), .winOut(winOut), .winValid(winValid),
  .winBusy(winBusy), .descDone(descDone)
);

// File: tb/sim_lbp_top.sv
`timescale 1ns/1ps
module sim_lbp_top;
  localparam int W = 48;
  localparam int WIN2 = 31;
  localparam int NPIX = 60 * W;
  localparam int H = 18;
  localparam int DLY = H * W + H + 1;
  localparam int FILL = 2 * H * W + 2 * H + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pixIn = '0;
  logic pixValid = 1'b0, featHit = 1'b0, descDone = 1'b0;
  logic pixReady, winValid, winBusy;
  logic [WIN2*WIN2*8-1:0] winOut;

  int checks = 0, fails = 0, k = 0;
  bit finished = 0;
  logic [7:0] raw [NPIX];

  always #4 clk = ~clk;

  lbp_top #(.W(W), .WIN2(WIN2)) u0 (.*);

  function automatic int wt(input int i);
    int t [7] = '{1, 6, 15, 20, 15, 6, 1};
    return t[i];
  endfunction

  function automatic int smoothAt(input int m);
    int ctr, s, idx, px;
    if (m < 0) return 0;
    ctr = m - 1 - (3 * W + 3);
    s = 0;
    for (int dr = -3; dr <= 3; dr++)
      for (int dc = -3; dc <= 3; dc++) begin
        idx = ctr + dr * W + dc;
        px = (idx < 0) ? 0 : int'(raw[idx]);
        s += wt(dr + 3) * wt(dc + 3) * px;
      end
    return (s + 2048) >>> 12;
  endfunction

  function automatic bit validAfter(input int n);
    int cc;
    if (n < FILL) return 0;
    cc = (n - 1 - DLY) % W;
    return (cc >= H) && (cc <= W - 1 - H);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmpWindow(input string req);
    int bad = 0, firstAct = 0, firstExp = 0, e;
    for (int r = 0; r < WIN2; r++)
      for (int c = 0; c < WIN2; c++) begin
        e = smoothAt(k - 1 - ((WIN2 - 1 - r) * W + (WIN2 - 1 - c)));
        if (int'(winOut[(r*WIN2+c)*8 +: 8]) != e) begin
          if (bad == 0) begin firstAct = int'(winOut[(r*WIN2+c)*8 +: 8]); firstExp = e; end
          bad++;
        end
      end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  task automatic serviceBusy();
    int hold;
    check(pixReady == 1'b0, "R7 ready low while busy", int'(pixReady), 0);
    cmpWindow("R2/R3/R5 patch at freeze");
    hold = 1 + int'($urandom % 4);
    pixValid = 1'b1; pixIn = 8'hAA; featHit = 1'b1;
    repeat (hold) begin
      @(posedge clk); @(negedge clk);
      check(winBusy == 1'b1, "R7 busy held", int'(winBusy), 1);
    end
    cmpWindow("R7 patch stable, stray pixel ignored");
    pixValid = 1'b0; featHit = 1'b0; descDone = 1'b1;
    @(posedge clk); @(negedge clk);
    descDone = 1'b0;
    check(winBusy == 1'b0 && pixReady == 1'b1, "R8 release after done",
          int'({winBusy, pixReady}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", k, NPIX);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit v, f, expV;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPIX; i++) raw[i] = 8'($urandom);
    for (int i = 20 * W; i < 23 * W; i++) raw[i] = 8'hFF;
    for (int i = 30 * W; i < 32 * W; i++) raw[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check(pixReady == 1'b1, "R1 reset ready", int'(pixReady), 1);
    check(winBusy == 1'b0, "R1 reset busy", int'(winBusy), 0);
    check(winValid == 1'b0, "R1 reset valid", int'(winValid), 0);
    check(winOut == '0, "R1 reset window", int'(winOut[7:0]), 0);
    while (k < NPIX) begin
      v = ($urandom % 8) != 0;
      f = ($urandom % 5) == 0;
      pixValid = v; pixIn = raw[k]; featHit = f;
      @(posedge clk); @(negedge clk);
      pixValid = 1'b0; featHit = 1'b0;
      if (v) begin
        k++;
        expV = validAfter(k);
        check(winValid == expV, "R4 valid flag", int'(winValid), int'(expV));
        if (f && !expV)
          check(winBusy == 1'b0 && pixReady == 1'b1, "R6 border flag ignored",
                int'({winBusy, pixReady}), 1);
        else
          check(winBusy == (f && expV), "R5 freeze on flag", int'(winBusy), int'(f && expV));
      end else begin
        check(winBusy == 1'b0, "R9 idle cycle no freeze", int'(winBusy), 0);
      end
      if (winBusy) serviceBusy();
    end
    cmpWindow("R9 final patch after gaps");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule